// File: doc/BRIEF.md
# Programmable Chip-Enable Decoder with Echo Strobe Gating

This block decides, once per clock, whether a pipelined synchronous memory bank is selected. It takes three chip-enable inputs. The first is always active low. The other two each have a polarity set by a static strap pin, so that two or four banks can share one enable bus and each bank answers to its own code.

The block produces a registered device select for the memory pipeline. It also produces an echo-strobe enable and a data-drive enable. Both of these are delayed to line up with read data on the pins.

The echo strobe is modelled as an enable plus two gated phase signals: a true copy and an inverted copy. Only the two strap-programmable enables can turn the echo strobe off. The fixed active-low enable deselects the device but leaves the echo running. This lets a controller pause between banks while the new bank's strobe is already toggling.

Top module: `cs_echo_gate`

## Requirements
- R1: The first enable `cs1_n` is active low: with the other two enables matching, `cs1_n`=1 gives `dev_sel`=0 and `cs1_n`=0 gives `dev_sel`=1.
- R2: Enable `cs2` is asserted when it equals `cs2_pol`, and `cs3` is asserted when it equals `cs3_pol` (strap value 1 = active high, 0 = active low). The straps are used without being registered.
- R3: `dev_sel` is 1 exactly when all three enables were asserted at the most recent rising edge, so it appears one cycle after sampling.
- R4: `echo_en` is 1 exactly when `cs2` and `cs3` were both asserted at the edge LAT cycles back (LAT=2 by default), whatever `cs1_n` was. After a deselect through `cs2` or `cs3`, `echo_en` stays 1 for one more cycle and then clears.
- R5: While `echo_en` is 1, `echo_t` toggles every cycle and `echo_c` is its inverse. While `echo_en` is 0, both are 0.
- R6: `data_oe` is 1 only for a read, meaning all three enables asserted and `wr_n`=1, sampled LAT edges back. It is 0 for writes and for any deselect, including a deselect through `cs1_n` alone.
- R7: During reset, and until a select through `cs2`/`cs3` has crossed the pipeline, `dev_sel`, `echo_en`, `data_oe`, `echo_t` and `echo_c` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all enables sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs1_n | input | 1 | Fixed-polarity enable, active low |
| cs2 | input | 1 | Strap-polarity enable, bank code bit |
| cs3 | input | 1 | Strap-polarity enable, bank code bit |
| cs2_pol | input | 1 | Static strap: active level of `cs2` |
| cs3_pol | input | 1 | Static strap: active level of `cs3` |
| wr_n | input | 1 | Access type: 1 read, 0 write |
| dev_sel | output | 1 | Registered device select for the memory pipeline |
| echo_en | output | 1 | Echo strobe enable, aligned with read data |
| echo_t | output | 1 | True echo phase, gated by `echo_en` |
| echo_c | output | 1 | Inverted echo phase, gated by `echo_en` |
| data_oe | output | 1 | Data-drive enable for read data |

## Verification
Each result has a fixed due time after the edge that samples the enables. `dev_sel` is due one cycle later. `echo_en` and `data_oe` are due two cycles later.

The bench changes inputs only on falling edges and reads outputs only on falling edges. It checks `dev_sel` at the first falling edge after the sampling edge and the delayed enables at the second. The deselect tests read the cycle in between as well, to show the echo lingering for exactly one cycle. The echo phase checks compare two consecutive falling edges to see the toggle.

// File: rtl/cs_echo_pkg.sv
package cs_echo_pkg;
   typedef struct packed {
      logic bank;   // cs2 and cs3 both asserted
      logic dev;    // all three enables asserted
      logic rd;     // dev and read access
   } sel_vec_t;
   localparam int SEL_W = $bits(sel_vec_t);
endpackage

// File: rtl/cs_decode.sv
module cs_decode
   import cs_echo_pkg::*;
(
   input  logic     cs1_n,
   input  logic     cs2,
   input  logic     cs3,
   input  logic     cs2_pol,
   input  logic     cs3_pol,
   input  logic     wr_n,
   output sel_vec_t hit
);
   logic m2, m3;
   always_comb begin
      m2       = (cs2 == cs2_pol);
      m3       = (cs3 == cs3_pol);
      hit.bank = m2 & m3;
      hit.dev  = hit.bank & ~cs1_n;
      hit.rd   = hit.dev & wr_n;
   end
endmodule

// File: rtl/sel_delay.sv
module sel_delay #(
   parameter int W     = 3,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q_first,
   output logic [W-1:0] q_last
);
   generate
      if (DEPTH < 1) begin : g_bad
         $error("sel_delay: DEPTH must be at least 1");
      end
      if (W < 1) begin : g_badw
         $error("sel_delay: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] stg [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   generate
      for (genvar i = 1; i < DEPTH; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
         end
      end
   endgenerate

   assign q_first = stg[0];
   assign q_last  = stg[DEPTH-1];
endmodule

// File: rtl/echo_gen.sv
module echo_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic echo_t,
   output logic echo_c
);
   logic ph;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph <= 1'b0;
      else        ph <= ~ph;
   end
   assign echo_t = en & ph;
   assign echo_c = en & ~ph;

   // R5: the two phases are never high together
   a_r5_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(echo_t && echo_c));
   // R5: both phases are silent while disabled
   a_r5_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (!echo_t && !echo_c));
   // R5: the true phase toggles on every cycle of an enabled run
   a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en)) |-> (echo_t != $past(echo_t)));
endmodule

// File: rtl/cs_echo_gate.sv
module cs_echo_gate
   import cs_echo_pkg::*;
#(
   parameter int LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs1_n,
   input  logic cs2,
   input  logic cs3,
   input  logic cs2_pol,
   input  logic cs3_pol,
   input  logic wr_n,
   output logic dev_sel,
   output logic echo_en,
   output logic echo_t,
   output logic echo_c,
   output logic data_oe
);
   generate
      if (LAT < 1) begin : g_lat_bad
         $error("cs_echo_gate: LAT must be at least 1");
      end
   endgenerate

   sel_vec_t hit, s_first, s_last;

   cs_decode i_dec (
      .cs1_n(cs1_n), .cs2(cs2), .cs3(cs3),
      .cs2_pol(cs2_pol), .cs3_pol(cs3_pol),
      .wr_n(wr_n), .hit(hit)
   );

   sel_delay #(.W(SEL_W), .DEPTH(LAT)) i_dly (
      .clk(clk), .rst_n(rst_n), .d(hit),
      .q_first(s_first), .q_last(s_last)
   );

   assign dev_sel = s_first.dev;
   assign echo_en = s_last.bank;
   assign data_oe = s_last.rd;

   echo_gen i_echo (
      .clk(clk), .rst_n(rst_n), .en(echo_en),
      .echo_t(echo_t), .echo_c(echo_c)
   );

   // R6: data is driven only by a bank whose echo is alive
   a_r6_oe_needs_echo: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> echo_en);

   generate
      if (LAT == 2) begin : g_lat2_chk
         // R4: a device select one cycle ago means echo is on now
         a_r4_sel_then_echo: assert property (@(posedge clk) disable iff (!rst_n)
            $past(dev_sel) |-> echo_en);
      end
   endgenerate
endmodule

// File: tb/test_cs_echo_gate.sv
`timescale 1ns/100ps
module test_cs_echo_gate;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs1_n = 1'b1, cs2 = 1'b0, cs3 = 1'b0;
   logic cs2_pol = 1'b1, cs3_pol = 1'b1, wr_n = 1'b1;
   logic dev_sel, echo_en, echo_t, echo_c, data_oe;
   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   cs_echo_gate i_cs_echo_gate (
      .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(cs2), .cs3(cs3),
      .cs2_pol(cs2_pol), .cs3_pol(cs3_pol), .wr_n(wr_n),
      .dev_sel(dev_sel), .echo_en(echo_en), .echo_t(echo_t),
      .echo_c(echo_c), .data_oe(data_oe)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   // drive a pattern and hold it; check all results once settled
   task automatic hold_and_check(input logic c1n, input logic c2, input logic c3,
                                 input logic w, input string req);
      logic bank, dev;
      cs1_n = c1n; cs2 = c2; cs3 = c3; wr_n = w;
      bank = (c2 == cs2_pol) && (c3 == cs3_pol);
      dev  = bank && !c1n;
      @(negedge clk);
      chk({req, " dev_sel"}, dev_sel, dev);
      @(negedge clk);
      chk({req, " echo_en"}, echo_en, bank);
      chk({req, " data_oe"}, data_oe, dev && w);
   endtask

   task automatic t_reset;
      chk("R7 reset dev_sel", dev_sel, 1'b0);
      chk("R7 reset echo_en", echo_en, 1'b0);
      chk("R7 reset echo_t", echo_t, 1'b0);
      chk("R7 reset echo_c", echo_c, 1'b0);
      chk("R7 reset data_oe", data_oe, 1'b0);
   endtask

   task automatic t_first_enable;
      cs2_pol = 1'b1; cs3_pol = 1'b1;
      hold_and_check(1'b1, 1'b1, 1'b1, 1'b1, "R1 cs1_n high");
      hold_and_check(1'b0, 1'b1, 1'b1, 1'b1, "R1 cs1_n low");
   endtask

   task automatic t_polarity;
      cs2_pol = 1'b0; cs3_pol = 1'b1;
      hold_and_check(1'b0, 1'b0, 1'b1, 1'b1, "R2 pol01 match");
      hold_and_check(1'b0, 1'b1, 1'b1, 1'b1, "R2 pol01 miss");
      cs2_pol = 1'b0; cs3_pol = 1'b0;
      hold_and_check(1'b0, 1'b0, 1'b0, 1'b1, "R2 pol00 match");
      hold_and_check(1'b0, 1'b0, 1'b1, 1'b1, "R2 pol00 miss");
      cs2_pol = 1'b1; cs3_pol = 1'b0;
      hold_and_check(1'b0, 1'b1, 1'b0, 1'b1, "R2 pol10 match");
      cs2_pol = 1'b1; cs3_pol = 1'b1;
   endtask

   task automatic t_dev_latency;
      hold_and_check(1'b1, 1'b0, 1'b0, 1'b1, "R3 idle");
      cs1_n = 1'b0; cs2 = 1'b1; cs3 = 1'b1;
      chk("R3 before edge", dev_sel, 1'b0);
      @(negedge clk);
      chk("R3 one cycle", dev_sel, 1'b1);
      chk("R4 not yet", echo_en, 1'b0);
      @(negedge clk);
      chk("R4 two cycles", echo_en, 1'b1);
   endtask

   task automatic t_echo_deselect;
      hold_and_check(1'b0, 1'b1, 1'b1, 1'b1, "R4 selected");
      cs2 = 1'b0;
      @(negedge clk);
      chk("R3 cs2 drop dev_sel", dev_sel, 1'b0);
      chk("R4 echo lingers", echo_en, 1'b1);
      @(negedge clk);
      chk("R4 echo off", echo_en, 1'b0);
      chk("R6 oe off", data_oe, 1'b0);
   endtask

   task automatic t_cs1_keeps_echo;
      hold_and_check(1'b0, 1'b1, 1'b1, 1'b1, "R4 pre");
      hold_and_check(1'b1, 1'b1, 1'b1, 1'b1, "R4 cs1 deselect");
      chk("R4 echo alive on cs1 deselect", echo_en, 1'b1);
      chk("R6 no drive on cs1 deselect", data_oe, 1'b0);
   endtask

   task automatic t_echo_phase;
      logic prev;
      hold_and_check(1'b0, 1'b1, 1'b1, 1'b1, "R5 on");
      prev = echo_t;
      chk("R5 complement", echo_c, ~echo_t);
      @(negedge clk);
      chk("R5 toggle", echo_t, ~prev);
      chk("R5 complement 2", echo_c, prev);
      hold_and_check(1'b0, 1'b0, 1'b1, 1'b1, "R5 off");
      chk("R5 true off", echo_t, 1'b0);
      chk("R5 inv off", echo_c, 1'b0);
      @(negedge clk);
      chk("R5 true off 2", echo_t, 1'b0);
      chk("R5 inv off 2", echo_c, 1'b0);
   endtask

   task automatic t_write;
      hold_and_check(1'b0, 1'b1, 1'b1, 1'b0, "R6 write");
      chk("R6 write no drive", data_oe, 1'b0);
      hold_and_check(1'b0, 1'b1, 1'b1, 1'b1, "R6 read");
      chk("R6 read drive", data_oe, 1'b1);
   endtask

   initial begin
      #20000;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      chk("R7 after reset echo_en", echo_en, 1'b0);
      t_first_enable();
      t_polarity();
      t_dev_latency();
      t_echo_deselect();
      t_cs1_keeps_echo();
      t_echo_phase();
      t_write();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule